// File: doc/BRIEF.md
# Floating-Point Adder-Subtractor with Truncation

This block adds or subtracts two single-precision binary floating-point words and returns the result one clock later. One datapath serves both operations. A select input inverts the sign of the second operand, so subtraction becomes addition of a negated value.

The unit orders the operands by magnitude. The significand of the smaller operand is shifted right by the exponent difference. The bits shifted out are discarded, and no guard or sticky bits are kept. The two aligned significands are then summed or differenced. The raw result is normalized either by a one-place right shift or by a left shift set by a leading-zero count. The fraction field is the 23 bits that follow the leading one, cut off with no rounding.

Infinities, NaNs, subnormal inputs and exponent overflow are outside the scope of this block. An operand with a zero exponent field counts as zero. A result that would need a zero or negative exponent is flushed to positive zero.

Top module: `fp_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0x00000000 on that edge, whatever the operands are.
- R2: `result` shows the outcome for the operands and `op_sub` sampled at the previous rising edge. Latency is exactly one cycle, and a new operation can start every cycle.
- R3: The significand of the operand with the smaller exponent is logically right-shifted by the exponent difference before it is combined. When the difference is 24 or more, that significand contributes nothing, and the result equals the larger operand unchanged.
- R4: `op_sub` = 0 computes `opnd_a + opnd_b`. `op_sub` = 1 computes `opnd_a - opnd_b` by inverting bit 31 (the sign) of `opnd_b`.
- R5: When the significand sum carries out to the 2.x range, the result exponent is the larger exponent plus one. Example: 0x45D4FBAE + 0x454282E1 gives 0x461B1E8F.
- R6: When effective subtraction leaves leading zeros, the significand is shifted left until its leading one is in the hidden-bit position. The exponent drops by the same count. Example: 0x3F800001 - 0x3F800000 gives 0x34000000.
- R7: The result sign is the sign of the operand with the larger magnitude, compared on bits 30:0 after the R4 inversion. The magnitude is the larger significand minus the aligned smaller one.
- R8: An effective subtraction of two operands with equal bits 30:0 gives exactly 0x00000000.
- R9: The result fraction is truncated with no rounding. Example: 0x3F800000 + 0x34FFFFFF gives 0x3F800003.
- R10: An operand whose exponent field (bits 30:23) is zero is treated as zero, whatever its fraction bits hold.
- R11: A result whose normalized exponent would be zero or less is returned as 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sub | input | 1 | 0 selects addition, 1 selects subtraction |
| opnd_a | input | 32 | First operand (sign bit 31, exponent bits 30:23, fraction bits 22:0) |
| opnd_b | input | 32 | Second operand, same layout |
| result | output | 32 | Registered result, same layout |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths the one stated carry example can be checked literally, and the shift limit sits at exactly 24 positions, where the bench places vectors at differences of 23, 24 and 25. Directed vectors cover carry-out normalization, deep leading-zero normalization, truncation, cancellation, zero-exponent operands and flush to zero. Several hundred pseudo-random operand pairs, drawn with nearby exponents so that both the alignment and the cancellation paths are exercised, are then compared on every clock against a behavioural integer model.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic {
    FPAS_ADD = 1'b0,
    FPAS_SUB = 1'b1
  } fpas_op_e;
endpackage

// File: rtl/fpas_align.sv
// Operand unpack, magnitude ordering and alignment shift of the smaller significand.
module fpas_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0]  opa,
  input  logic [WORD_W-1:0]  opb,
  input  fpas_pkg::fpas_op_e op,
  output logic [EXP_W-1:0]   big_exp,
  output logic [SIG_W-1:0]   big_sig,
  output logic [SIG_W-1:0]   small_sig,
  output logic               res_sign,
  output logic               eff_sub
);
  localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(SIG_W);

  logic              sign_a, sign_b;
  logic [EXP_W-1:0]  exp_a, exp_b, small_exp, exp_diff;
  logic [SIG_W-1:0]  sig_a, sig_b, small_raw;
  logic              b_larger;

  always_comb begin
    sign_a = opa[WORD_W-1];
    sign_b = opb[WORD_W-1] ^ (op == fpas_pkg::FPAS_SUB);
    exp_a  = opa[WORD_W-2:FRAC_W];
    exp_b  = opb[WORD_W-2:FRAC_W];
    // a zero exponent field means the operand is zero
    sig_a  = (exp_a != '0) ? {1'b1, opa[FRAC_W-1:0]} : '0;
    sig_b  = (exp_b != '0) ? {1'b1, opb[FRAC_W-1:0]} : '0;
    b_larger = {exp_b, sig_b} > {exp_a, sig_a};

    if (b_larger) begin
      big_exp   = exp_b;
      big_sig   = sig_b;
      small_exp = exp_a;
      small_raw = sig_a;
      res_sign  = sign_b;
    end else begin
      big_exp   = exp_a;
      big_sig   = sig_a;
      small_exp = exp_b;
      small_raw = sig_b;
      res_sign  = sign_a;
    end

    exp_diff  = big_exp - small_exp;
    small_sig = (exp_diff >= SHIFT_LIM) ? '0 : (small_raw >> exp_diff);
    eff_sub   = sign_a ^ sign_b;
  end
endmodule

// File: rtl/fpas_lzc.sv
// Leading-zero counter; an all-zero vector yields W.
module fpas_lzc #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fpas_norm.sv
// Post-combine normalization: carry right shift or leading-zero left shift, then truncation.
module fpas_norm #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int LZ_W   = $clog2(SIG_W + 1)
) (
  input  logic               sign,
  input  logic [EXP_W-1:0]   big_exp,
  input  logic [SIG_W:0]     raw_sum,
  output logic [WORD_W-1:0]  word
);
  logic [LZ_W-1:0]  lz;
  logic [EXP_W-1:0] lz_ext;
  logic [SIG_W-1:0] shifted;
  logic [EXP_W-1:0] exp_up;

  fpas_lzc #(.W(SIG_W)) u_lzc (
    .vec (raw_sum[SIG_W-1:0]),
    .cnt (lz)
  );

  always_comb begin
    lz_ext  = EXP_W'(lz);
    shifted = raw_sum[SIG_W-1:0] << lz;
    exp_up  = big_exp + 1'b1;
    if (raw_sum[SIG_W]) begin
      word = {sign, exp_up, raw_sum[SIG_W-1:1]};
    end else if (raw_sum == '0 || lz_ext >= big_exp) begin
      word = '0;
    end else begin
      word = {sign, big_exp - lz_ext, shifted[SIG_W-2:0]};
    end
  end
endmodule

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic [WORD_W-1:0] result
);
  logic [EXP_W-1:0]  big_exp;
  logic [SIG_W-1:0]  big_sig, small_sig;
  logic              res_sign, eff_sub;
  logic [SIG_W:0]    raw_sum;
  logic [WORD_W-1:0] word_d;

  fpas_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .opa       (opnd_a),
    .opb       (opnd_b),
    .op        (fpas_pkg::fpas_op_e'(op_sub)),
    .big_exp   (big_exp),
    .big_sig   (big_sig),
    .small_sig (small_sig),
    .res_sign  (res_sign),
    .eff_sub   (eff_sub)
  );

  always_comb begin
    if (eff_sub) raw_sum = {1'b0, big_sig} - {1'b0, small_sig};
    else         raw_sum = {1'b0, big_sig} + {1'b0, small_sig};
  end

  fpas_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .sign    (res_sign),
    .big_exp (big_exp),
    .raw_sum (raw_sum),
    .word    (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= word_d;
  end

  // ---------------- assertions ----------------
  logic [EXP_W:0] ea_w, eb_w;
  assign ea_w = {1'b0, opnd_a[WORD_W-2:FRAC_W]};
  assign eb_w = {1'b0, opnd_b[WORD_W-2:FRAC_W]};

  // R8: equal magnitudes under effective subtraction cancel to +0
  a_r8_exact_cancel: assert property (@(posedge clk) disable iff (rst)
    ((opnd_a[WORD_W-2:0] == opnd_b[WORD_W-2:0]) &&
     ((opnd_a[WORD_W-1] ^ opnd_b[WORD_W-1]) != op_sub))
    |=> (result == '0));

  // R7: sign follows the larger-magnitude operand
  a_r7_sign_of_larger: assert property (@(posedge clk) disable iff (rst)
    (opnd_a[WORD_W-2:0] > opnd_b[WORD_W-2:0])
    |=> (result == '0 || result[WORD_W-1] == $past(opnd_a[WORD_W-1])));

  // R3: exponent gap of SIG_W or more leaves the larger operand untouched
  a_r3_far_operand_lost: assert property (@(posedge clk) disable iff (rst)
    ((ea_w >= eb_w + (EXP_W+1)'(SIG_W)) && (ea_w != '0))
    |=> (result == $past(opnd_a)));

  // R10: zero exponent field acts as zero
  a_r10_zero_exp_operand: assert property (@(posedge clk) disable iff (rst)
    ((eb_w == '0) && (ea_w != '0))
    |=> (result == $past(opnd_a)));
endmodule

// File: tb/sim_fp_addsub.sv
module sim_fp_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_sub = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [31:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  fp_addsub u0 (
    .clk    (clk),
    .rst    (rst),
    .op_sub (op_sub),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .result (result)
  );

  // Behavioural model built from the requirements.
  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, input logic s);
    int     ea, eb, ebig, esml, d, p, e;
    longint ma, mb, mbig, msml, sum, fr;
    logic   sa, sb, sg;
    sa = a[31];
    sb = b[31] ^ s;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    ma = (ea != 0) ? (longint'(1) << 23) + longint'(a[22:0]) : 0;
    mb = (eb != 0) ? (longint'(1) << 23) + longint'(b[22:0]) : 0;
    if ((longint'(eb) << 24) + mb > (longint'(ea) << 24) + ma) begin
      ebig = eb; mbig = mb; esml = ea; msml = ma; sg = sb;
    end else begin
      ebig = ea; mbig = ma; esml = eb; msml = mb; sg = sa;
    end
    d = ebig - esml;
    msml = (d >= 24) ? 0 : (msml >> d);
    sum = (sa != sb) ? mbig - msml : mbig + msml;
    if (sum == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 26; i++) if (sum[i]) p = i;
    e = ebig + p - 23;
    if (e <= 0) return 32'h0;
    fr = (p >= 23) ? (sum >> (p - 23)) : (sum << (23 - p));
    return {sg, e[7:0], fr[22:0]};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string tag);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: result=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // Compare the previous operation, then drive the next one (R2: one-cycle latency).
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s, input string tag);
    @(negedge clk);
    if (exp_q.size() > 0) check(result, exp_q.pop_front(), tag_q.pop_front());
    opnd_a = a; opnd_b = b; op_sub = s;
    exp_q.push_back(model(a, b, s));
    tag_q.push_back(tag);
  endtask

  task automatic apply_lit(input logic [31:0] a, input logic [31:0] b, input logic s,
                           input logic [31:0] expv, input string tag);
    @(negedge clk);
    if (exp_q.size() > 0) check(result, exp_q.pop_front(), tag_q.pop_front());
    opnd_a = a; opnd_b = b; op_sub = s;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  initial begin
    // R1: reset clears the output even with operands present
    opnd_a = 32'h3F800000; opnd_b = 32'h40000000;
    repeat (3) @(negedge clk);
    check(result, 32'h0, "R1 reset state");
    rst = 1'b0;

    apply_lit(32'h45D4FBAE, 32'h454282E1, 1'b0, 32'h461B1E8F, "R5 carry normalization");
    apply_lit(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, "R6 deep left normalization");
    apply_lit(32'h3F800000, 32'h3F000000, 1'b1, 32'h3F000000, "R4 subtract select");
    apply_lit(32'h3F800000, 32'h3F000000, 1'b0, 32'h3FC00000, "R4 add select");
    apply_lit(32'h3F800000, 32'h34FFFFFF, 1'b0, 32'h3F800003, "R9 truncation");
    apply_lit(32'h3F800000, 32'h33000000, 1'b0, 32'h3F800000, "R3 gap 25");
    apply_lit(32'h3F800000, 32'h33800000, 1'b1, 32'h3F800000, "R3 gap 24");
    apply_lit(32'h3F800000, 32'h34000000, 1'b0, 32'h3F800001, "R3 gap 23");
    apply_lit(32'h40490FDB, 32'h40490FDB, 1'b1, 32'h00000000, "R8 cancel by subtract");
    apply_lit(32'hC0490FDB, 32'h40490FDB, 1'b0, 32'h00000000, "R8 cancel by add");
    apply_lit(32'h3F800000, 32'h007FFFFF, 1'b0, 32'h3F800000, "R10 zero exponent operand");
    apply_lit(32'h00000000, 32'h00000000, 1'b1, 32'h00000000, "R10 both zero");
    apply_lit(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R11 flush to zero");
    apply_lit(32'h3F000000, 32'h3F800000, 1'b1, 32'hBF000000, "R7 larger operand negative");
    apply(32'h3E39C0EB, 32'hC6132F3D, 1'b0, "R7 mixed signs");
    apply(32'h3E39C0EB, 32'h46132F3D, 1'b1, "R7 subtract larger");
    // R2: back-to-back different operations
    apply_lit(32'h40000000, 32'h40000000, 1'b0, 32'h40800000, "R2 back-to-back first");
    apply_lit(32'h40000000, 32'h3F800000, 1'b1, 32'h3F800000, "R2 back-to-back second");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      int ea, eb;
      ea = $urandom_range(1, 250);
      eb = ea + $urandom_range(0, 60) - 30;
      if (eb < 1) eb = 1;
      if (eb > 250) eb = 250;
      if (i % 20 == 7) eb = 0;
      a = {1'($urandom), 8'(ea), 23'($urandom)};
      b = {1'($urandom), 8'(eb), 23'($urandom)};
      if (i % 25 == 3) b = a;
      if (i % 9 == 4) b[30:23] = a[30:23];
      apply(a, b, 1'($urandom), "R3/R6/R7/R9 random");
    end

    @(negedge clk);
    if (exp_q.size() > 0) check(result, exp_q.pop_front(), tag_q.pop_front());
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: result=%08h expected=run complete", result);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule